// File: doc/BRIEF.md
# Byte-Lane SRAM Read Sequencer

This block fetches an 8-, 16- or 32-bit value from an external asynchronous SRAM whose byte-wide data bus and 24-bit byte address share one 32-bit general-purpose pin port. Port bits 31..8 carry the address as outputs and port bits 7..0 are inputs that carry the returned data byte. A requester hands over a start address and a size code. The block then walks the byte addresses of the access from the highest down to the lowest. It holds each address for a settle interval, samples the data lines and drops the byte into its little-endian lane of the result.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole read, so a requester that holds `req_valid` high simply waits, and a valid seen while busy starts nothing. The result side has no back-pressure: `rsp_done` pulses for one cycle and `rsp_data` keeps its value until the next request is accepted, so a consumer may read it at any later time.

The settle interval is the parameter `SETTLE` in clock cycles (default 1). This suits fast SRAM at the default and lets slower parts be used with a larger value.

Top module: `sram_byte_reader`

## Requirements
- R1: The address is driven on port bits 31..8 (port value = address shifted left by 8, bits 7..0 driven 0), and data is taken only from `port_in[7:0]`; `port_in[31:8]` has no effect on the result.
- R2: `port_dir` (1 = output) is 0xFFFFFF00 in every cycle from the one after acceptance up to and including the cycle of the final sample, and 0x00000000 in all other cycles.
- R3: Size codes: 0 reads one byte, 1 reads two bytes, 2 reads four bytes, and 3 is treated as a four-byte read.
- R4: The first address driven is base + bytes − 1, and after each sample the address falls by one (port value falls by 0x100) until base has been read.
- R5: The byte read from address base+n is placed in `rsp_data` bits 8n+7..8n; lanes above the access size read as zero.
- R6: Each address is held for SETTLE+1 cycles and sampled at the end of the last one, so `rsp_done` appears bytes×(SETTLE+1) cycles after the accepting edge.
- R7: `req_ready` is high only while idle; a `req_valid` raised during a read is ignored and starts no further access.
- R8: `rsp_done` is high for exactly one cycle per read, and `rsp_data` does not change from then until the next acceptance.
- R9: An active-low synchronous reset, even mid-read, returns the block to idle with `port_dir` = 0, `port_out` = 0, `rsp_done` = 0, `rsp_data` = 0 and `req_ready` = 1.
- R10: Byte addresses wrap modulo 2^24, so a read whose top byte passes 0xFFFFFF continues from 0x000000 downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 24 | Start (lowest) byte address |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 or 3 word |
| rsp_done | output | 1 | One-cycle pulse: result complete |
| rsp_data | output | 32 | Assembled little-endian result |
| port_in | input | 32 | Pin input values; bits 7..0 are SRAM data |
| port_out | output | 32 | Pin output values; bits 31..8 are the address |
| port_dir | output | 32 | Pin direction mask, 1 = output |

## Verification
The SRAM model in the bench returns a byte that depends on every address bit and puts a fixed junk pattern on the upper input lines. A result in the wrong lane, from the wrong address, or polluted by the address half of the port therefore shows up as a wrong value. Reads of each size at several bases separate the lane count and the zero fill of unused lanes. A word read across the top of the address space separates correct 24-bit wrap from a carry into a wider sum. A cycle-by-cycle trace of `port_out` and `port_dir` against the expected descending address and hold length shows whether the order and the settle time are right. A valid raised mid-read and a reset mid-read show whether busy requests are discarded and whether reset abandons the access.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  // Result lanes: a word access is the widest and needs four bytes.
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } rd_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } rd_state_e;

  // Number of bytes fetched for a size code.
  function automatic logic [2:0] lane_count(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_count = 3'd1;
      SZ_HALF: lane_count = 3'd2;
      default: lane_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl
  import sram_rd_pkg::*;
#(
  parameter int SETTLE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_size,
  output logic       req_ready,
  output logic       load,
  output logic       capture,
  output logic       last,
  output logic [1:0] lane_idx,
  output logic       done
);

  localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE);
  localparam rd_state_e AFTER_ADDR = (SETTLE == 0) ? ST_SAMPLE : ST_SETTLE;

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       idx_q;
  logic             done_q;

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_valid && req_ready;
  assign capture   = (state_q == ST_SAMPLE);
  assign last      = capture && (idx_q == 2'd0);
  assign lane_idx  = idx_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      case (state_q)
        ST_IDLE: begin
          if (load) begin
            idx_q   <= 2'(lane_count(req_size) - 3'd1);
            cnt_q   <= CNT_INIT;
            state_q <= AFTER_ADDR;
          end
        end
        ST_SETTLE: begin
          if (cnt_q <= CNT_W'(1)) begin
            state_q <= ST_SAMPLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SAMPLE: begin
          if (idx_q == 2'd0) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q - 2'd1;
            cnt_q   <= CNT_INIT;
            state_q <= AFTER_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_rd_addr.sv
module sram_rd_addr
  import sram_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     capture,
  input  logic                     last,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  output logic [ADDR_W+LANE_W-1:0] port_out,
  output logic [ADDR_W+LANE_W-1:0] port_dir
);

  localparam int PORT_W = ADDR_W + LANE_W;
  localparam logic [PORT_W-1:0] READ_MASK = {{ADDR_W{1'b1}}, {LANE_W{1'b0}}};

  logic [ADDR_W-1:0] addr_q;
  logic              drive_q;

  // Highest byte first; addresses wrap within ADDR_W bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      if (load) begin
        addr_q  <= req_addr + ADDR_W'(lane_count(req_size) - 3'd1);
        drive_q <= 1'b1;
      end else if (capture) begin
        if (last) begin
          drive_q <= 1'b0;
        end else begin
          addr_q <= addr_q - ADDR_W'(1);
        end
      end
    end
  end

  assign port_out = {addr_q, {LANE_W{1'b0}}};
  assign port_dir = drive_q ? READ_MASK : '0;

endmodule

// File: rtl/sram_rd_assemble.sv
module sram_rd_assemble #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    capture,
  input  logic [1:0]              lane_idx,
  input  logic [LANE_W-1:0]       sample,
  output logic [LANES*LANE_W-1:0] data
);

  // Each lane clears on a new request and loads only when its index is sampled.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (load) begin
        lane_q <= '0;
      end else if (capture && (lane_idx == 2'(g))) begin
        lane_q <= sample;
      end
    end
    assign data[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sram_byte_reader.sv
module sram_byte_reader
  import sram_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8,
  parameter int SETTLE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  output logic                     rsp_done,
  output logic [LANES*LANE_W-1:0]  rsp_data,
  input  logic [ADDR_W+LANE_W-1:0] port_in,
  output logic [ADDR_W+LANE_W-1:0] port_out,
  output logic [ADDR_W+LANE_W-1:0] port_dir
);

  localparam int PORT_W = ADDR_W + LANE_W;

  logic             load;
  logic             capture;
  logic             last;
  logic [1:0]       lane_idx;
  logic [LANE_W-1:0] data_byte;
  logic [PORT_W-LANE_W-1:0] unused_port_hi;

  assign data_byte      = port_in[LANE_W-1:0];
  assign unused_port_hi = port_in[PORT_W-1:LANE_W];

  sram_rd_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_ready (req_ready),
    .load      (load),
    .capture   (capture),
    .last      (last),
    .lane_idx  (lane_idx),
    .done      (rsp_done)
  );

  sram_rd_addr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .capture  (capture),
    .last     (last),
    .req_addr (req_addr),
    .req_size (req_size),
    .port_out (port_out),
    .port_dir (port_dir)
  );

  sram_rd_assemble #(.LANE_W(LANE_W), .LANES(LANES)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .capture  (capture),
    .lane_idx (lane_idx),
    .sample   (data_byte),
    .data     (rsp_data)
  );

endmodule

// File: rtl/sram_byte_reader_chk.sv
module sram_byte_reader_chk #(
  parameter int PORT_W = 32,
  parameter int LANE_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_data,
  input logic [PORT_W-1:0] port_out,
  input logic [PORT_W-1:0] port_dir
);

  localparam logic [PORT_W-1:0] MASK = {{(PORT_W-LANE_W){1'b1}}, {LANE_W{1'b0}}};
  localparam logic [PORT_W-1:0] STEP = PORT_W'(1) << LANE_W;

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> (port_dir == '0 && req_ready && !rsp_done));

  p_dir_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> port_dir == MASK);

  p_dir_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> port_dir == '0);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready) && !$stable(port_out))
      |-> port_out == $past(port_out) - STEP);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(rsp_data));

endmodule

bind sram_byte_reader sram_byte_reader_chk #(
  .PORT_W (ADDR_W + LANE_W),
  .LANE_W (LANE_W),
  .DATA_W (sram_rd_pkg::LANES * LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_data  (rsp_data),
  .port_out  (port_out),
  .port_dir  (port_dir)
);

// File: tb/sram_byte_reader_tb.sv
module sram_byte_reader_tb;

  localparam int S = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_done;
  logic [31:0] rsp_data;
  logic [31:0] port_in;
  logic [31:0] port_out;
  logic [31:0] port_dir;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_data[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  sram_byte_reader #(.SETTLE(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .port_in(port_in), .port_out(port_out),
    .port_dir(port_dir)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] ^ a[15:8] ^ a[23:16]) + 8'h37;
  endfunction

  // SRAM model; junk on the address half of the input port (R1).
  assign port_in = {24'hC3A5F0, mem_byte(port_out[31:8])};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: scoreboard pop on each completion.
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_data.size() == 0) begin
        chk(1'b0, "R8 done without request", rsp_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_data.pop_front();
        t = exp_tag.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic do_read(input logic [23:0] base, input logic [1:0] sz,
                         input bit junk, input string tag);
    int nb;
    int total;
    logic [31:0] e;
    logic [23:0] ea;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    total = nb * (S + 1);
    e = '0;
    for (int n = 0; n < nb; n++) e[8*n +: 8] = mem_byte(base + 24'(n));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = base; req_size = sz;
    exp_data.push_back(e);
    exp_tag.push_back(tag);
    for (int cyc = 1; cyc <= total; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        req_valid = junk;            // R7: offered while busy
        req_addr  = base ^ 24'h00F0F0;
        req_size  = 2'd2;
      end else if (cyc == 2) begin
        req_valid = 1'b0;
      end
      ea = base + 24'(nb - 1 - (cyc - 1) / (S + 1));
      chk(port_out == {ea, 8'h00}, "R4 R10 address order", port_out, {ea, 8'h00});
      chk(port_dir == 32'hFFFFFF00, "R2 mask during read", port_dir, 32'hFFFFFF00);
      chk(!req_ready && !rsp_done, "R6 R7 busy without done",
          {30'h0, req_ready, rsp_done}, 32'h0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_done == 1'b1, "R6 done latency", {31'h0, rsp_done}, 32'h1);
    chk(port_dir == 32'h0, "R2 mask released", port_dir, 32'h0);
    chk(req_ready == 1'b1, "R7 ready after read", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8 done one cycle", {31'h0, rsp_done}, 32'h0);
    chk(rsp_data == e, "R8 result held", rsp_data, e);
    chk(req_ready == 1'b1, "R7 busy request ignored", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(port_dir == 32'h0 && port_out == 32'h0, "R9 reset port", port_dir | port_out, 32'h0);
    chk(req_ready && !rsp_done && rsp_data == 32'h0, "R9 reset idle",
        rsp_data, 32'h0);
    rst_n = 1'b1;

    do_read(24'h000040, 2'd0, 1'b0, "R1 R5 byte read");
    do_read(24'h004000, 2'd1, 1'b0, "R3 R5 halfword read");
    do_read(24'h004000, 2'd2, 1'b0, "R3 R5 word read");
    do_read(24'h123457, 2'd3, 1'b0, "R3 size code 3 as word");
    do_read(24'hABCDEF, 2'd1, 1'b1, "R7 halfword with busy request");
    do_read(24'h7F00FC, 2'd2, 1'b1, "R7 word with busy request");
    do_read(24'hFFFFFE, 2'd2, 1'b0, "R10 wrap word read");
    do_read(24'hFFFFFF, 2'd1, 1'b0, "R10 wrap halfword read");
    do_read(24'h000001, 2'd0, 1'b0, "R5 byte zero fill");

    // R8: result holds while idle
    repeat (4) @(negedge clk);
    chk(rsp_data == {24'h0, mem_byte(24'h000001)}, "R8 hold while idle",
        rsp_data, {24'h0, mem_byte(24'h000001)});

    // R9: reset in the middle of a word read
    req_valid = 1'b1; req_addr = 24'h00A000; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    exp_data.delete();
    exp_tag.delete();
    chk(port_dir == 32'h0 && port_out == 32'h0, "R9 reset mid read port",
        port_dir | port_out, 32'h0);
    chk(req_ready && !rsp_done && rsp_data == 32'h0, "R9 reset mid read idle",
        rsp_data, 32'h0);
    rst_n = 1'b1;
    repeat (2 * 4 * (S + 1)) @(negedge clk);
    chk(!rsp_done && port_dir == 32'h0, "R9 abandoned read stays idle",
        port_dir, 32'h0);

    do_read(24'h00A000, 2'd2, 1'b0, "R9 read after reset");
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

endmodule